// File: doc/BRIEF.md
# Nine-Bit Addressable Serial Transceiver

This block is a full-duplex asynchronous serial transceiver that always carries nine data bits per character, for use on a shared multidrop line. The ninth bit marks a character as an address (1) or as data (0). A receiver attention state lets a node ignore traffic meant for other nodes. While attention is on, data characters are dropped without disturbing any flag. The first address character is delivered to the host, and the hardware then leaves attention by itself so that the following data reaches the host. The host decides whether to keep listening or to re-arm attention and wait for the next address.

The host side is a set of plain register-style signals. These cover a transmit byte with its ninth bit and a write strobe, a receive byte with its ninth bit, flags for buffer full, framing error and overrun, an interrupt enable, and a read strobe. Timing comes from an external oversampling tick at a fixed number of ticks per bit. A test loopback joins the transmit shift output to the receive shift input inside the block. A break control pulls the serial output low for as long as it is held.

Top module: `mp9_uart`

## Requirements
- R1: A transmitted frame is one low start bit, the 8 data bits LSB first, then the ninth bit, then one high stop bit (two when `cfg_stop2` is 1). Each bit lasts OVS ticks of `baud_tick`, and the start bit begins on the clock edge that accepts `tx_wr`.
- R2: `tx_busy` goes high on the edge that accepts a write and falls on the tick that ends the last stop bit. A `tx_wr` pulse while `tx_busy` is high is ignored.
- R3: The receiver checks a start bit at its middle sample. A low pulse shorter than half a bit produces no character.
- R4: A character that is accepted loads `rx_data` and `rx_bit9` and sets `rx_full`. `rx_irq` equals `rx_full` AND `rx_irq_en`.
- R5: A pulse on `rx_read` clears `rx_full`, `rx_ferr` and `rx_ovr`.
- R6: `rx_ferr` is set when the first stop bit samples low.
- R7: `rx_ovr` is set when a character is accepted while `rx_full` is already 1 and no read arrives in that cycle. The buffer then holds the newer character.
- R8: While `attn_mode` is 1, a character whose ninth bit is 0 is dropped. The data, flags and attention state all stay unchanged.
- R9: While `attn_mode` is 1, a character whose ninth bit is 1 is accepted as in R4 and `attn_mode` is cleared, so that later data characters are delivered.
- R10: A pulse on `attn_set` sets `attn_mode`, and it stays set until an address character is accepted.
- R11: The transmitter output is identical with `attn_mode` at 0 and at 1.
- R12: When `cfg_loop_sel` is 2'b11, the transmit shift output drives the receiver, `rxd` is ignored and `txd` stays high. Any other value leaves the serial pins in normal use.
- R13: While `cfg_break` is 1, `txd` is 0, whether the line is idle or a frame is being sent.
- R14: When a character completes in the same cycle as `rx_read`, the new character is kept, `rx_full` stays 1 and `rx_ovr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling tick, OVS ticks per bit |
| cfg_stop2 | input | 1 | Transmit two stop bits |
| cfg_loop_sel | input | 2 | 2'b11 selects internal loopback |
| cfg_break | input | 1 | Force the serial output low |
| tx_wr | input | 1 | Write strobe for a transmit character |
| tx_data | input | DATA_W | Transmit byte |
| tx_bit9 | input | 1 | Transmit ninth bit (address flag) |
| tx_busy | output | 1 | Transmit frame in progress |
| attn_set | input | 1 | Arm the attention state |
| attn_mode | output | 1 | Attention state |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rx_read | input | 1 | Host read strobe for the receive buffer |
| rx_data | output | DATA_W | Received byte |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_full | output | 1 | Receive buffer full |
| rx_ferr | output | 1 | Framing error |
| rx_ovr | output | 1 | Overrun |
| rx_irq | output | 1 | Receive interrupt |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
Two receive-side events can land on the same clock edge: a character completing and the host read that empties the buffer. The bench provokes this in loopback with the tick held high every cycle. That makes the completion edge an exact count of cycles after the transmit write, so the read strobe can be placed on that edge and the one before it. The expected result is the new character in the buffer with the full flag still set and no overrun. A read-wins or overrun-on-read design leaves a cleared flag or a set overrun, and the bench reports either one.

// File: rtl/mpu9_pkg.sv
package mpu9_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   localparam logic [1:0] LOOP_ON = 2'b11;

   function automatic int unsigned frame_len(input int unsigned char_w, input logic two_stop);
      return char_w + 2 + (two_stop ? 1 : 0);
   endfunction

endpackage

// File: rtl/mpu9_sync.sv
module mpu9_sync #(
   parameter int unsigned STAGES = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES == 0) begin : g_pass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] stg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= {STAGES{RST_VAL}};
            else        stg_q <= {stg_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_in} ;
         end
         assign d_out = stg_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mpu9_tx.sv
module mpu9_tx
   import mpu9_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   input  logic              bit9,
   input  logic              stop2,
   output logic              busy,
   output logic              line
);
   localparam int unsigned CHAR_W  = DATA_W + 1;
   localparam int unsigned FRAME_W = CHAR_W + 3;
   localparam int unsigned CNT_W   = $clog2(OVS);
   localparam int unsigned BL_W    = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   tcnt_q;
   logic [BL_W-1:0]    left_q;
   logic               busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         tcnt_q <= '0;
         left_q <= '0;
         busy_q <= 1'b0;
      end else if (load && !busy_q) begin
         sh_q   <= {2'b11, bit9, data, 1'b0};
         tcnt_q <= '0;
         left_q <= BL_W'(frame_len(CHAR_W, stop2));
         busy_q <= 1'b1;
      end else if (busy_q && tick) begin
         if (tcnt_q == CNT_LAST) begin
            tcnt_q <= '0;
            sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
            if (left_q == BL_W'(1)) busy_q <= 1'b0;
         end else begin
            tcnt_q <= tcnt_q + 1'b1;
         end
      end
   end

   assign busy = busy_q;
   assign line = busy_q ? sh_q[0] : 1'b1;

   // R1: a frame opens with a low start bit
   assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> !line);
   // R1: the last bit before the transmitter goes idle is a high stop bit
   assert_stop_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(line));
   // R2: the transmitter only goes idle on a tick
   assert_idle_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(tick));
endmodule

// File: rtl/mpu9_rx.sv
module mpu9_rx
   import mpu9_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_in,
   output logic              done,
   output logic [DATA_W:0]   char_o,
   output logic              stop_ok
);
   localparam int unsigned CHAR_W = DATA_W + 1;
   localparam int unsigned CNT_W  = $clog2(OVS);
   localparam int unsigned NB_W   = $clog2(CHAR_W + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);

   rx_state_e         st_q;
   logic [CNT_W-1:0]  rcnt_q;
   logic [NB_W-1:0]   nb_q;
   logic [CHAR_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RX_IDLE;
         rcnt_q <= '0;
         nb_q   <= '0;
         sh_q   <= '0;
      end else if (tick) begin
         unique case (st_q)
            RX_IDLE: begin
               if (!rx_in) begin
                  st_q   <= RX_START;
                  rcnt_q <= '0;
               end
            end
            RX_START: begin
               if (rcnt_q == CNT_MID) begin
                  rcnt_q <= '0;
                  nb_q   <= '0;
                  st_q   <= rx_in ? RX_IDLE : RX_DATA;
               end else begin
                  rcnt_q <= rcnt_q + 1'b1;
               end
            end
            RX_DATA: begin
               if (rcnt_q == CNT_LAST) begin
                  rcnt_q <= '0;
                  sh_q   <= {rx_in, sh_q[CHAR_W-1:1]};
                  nb_q   <= nb_q + 1'b1;
                  if (nb_q == NB_W'(CHAR_W - 1)) st_q <= RX_STOP;
               end else begin
                  rcnt_q <= rcnt_q + 1'b1;
               end
            end
            RX_STOP: begin
               if (rcnt_q == CNT_LAST) begin
                  rcnt_q <= '0;
                  st_q   <= RX_IDLE;
               end else begin
                  rcnt_q <= rcnt_q + 1'b1;
               end
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   assign done    = tick && (st_q == RX_STOP) && (rcnt_q == CNT_LAST);
   assign char_o  = sh_q;
   assign stop_ok = rx_in;

   // R3: a start bit that is high at its middle sample returns the receiver to idle
   assert_glitch_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && st_q == RX_START && rcnt_q == CNT_MID && rx_in) |=> st_q == RX_IDLE);
endmodule

// File: rtl/mpu9_rxctl.sv
module mpu9_rxctl #(
   parameter int unsigned DATA_W   = 8,
   parameter logic        ATTN_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W:0]   char_in,
   input  logic              stop_ok,
   input  logic              rd,
   input  logic              attn_set,
   input  logic              irq_en,
   output logic [DATA_W:0]   buf_o,
   output logic              full,
   output logic              ferr,
   output logic              ovr,
   output logic              attn,
   output logic              irq
);
   logic [DATA_W:0] buf_q;
   logic            full_q, ferr_q, ovr_q, attn_q;
   logic            is_addr, accept;

   assign is_addr = char_in[DATA_W];
   assign accept  = done && (!attn_q || is_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         full_q <= 1'b0;
         ferr_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else if (accept) begin
         buf_q  <= char_in;
         full_q <= 1'b1;
         ferr_q <= rd ? !stop_ok : (ferr_q | !stop_ok);
         ovr_q  <= rd ? 1'b0 : (ovr_q | full_q);
      end else if (rd) begin
         full_q <= 1'b0;
         ferr_q <= 1'b0;
         ovr_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        attn_q <= ATTN_RST;
      else if (attn_set)                 attn_q <= 1'b1;
      else if (accept && is_addr)        attn_q <= 1'b0;
   end

   assign buf_o = buf_q;
   assign full  = full_q;
   assign ferr  = ferr_q;
   assign ovr   = ovr_q;
   assign attn  = attn_q;
   assign irq   = full_q && irq_en;

   // R8: a data character seen in attention leaves buffer and flag untouched
   assert_attn_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && attn_q && !char_in[DATA_W] && !rd) |=> $stable(full_q) && $stable(buf_q));
   // R9: an address character seen in attention is delivered and ends attention
   assert_addr_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && attn_q && char_in[DATA_W] && !attn_set) |=> full_q && !attn_q);
   // R7: an unread buffer hit by a new character records an overrun
   assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && full_q && !rd) |=> ovr_q);
   // R14: completion together with a read keeps the new character without overrun
   assert_read_collide_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && rd) |=> full_q && !ovr_q);
endmodule

// File: rtl/mp9_uart.sv
module mp9_uart
   import mpu9_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        ATTN_RST    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              cfg_stop2,
   input  logic [1:0]        cfg_loop_sel,
   input  logic              cfg_break,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_bit9,
   output logic              tx_busy,
   input  logic              attn_set,
   output logic              attn_mode,
   input  logic              rx_irq_en,
   input  logic              rx_read,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit9,
   output logic              rx_full,
   output logic              rx_ferr,
   output logic              rx_ovr,
   output logic              rx_irq,
   input  logic              rxd,
   output logic              txd
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("mp9_uart: OVS must be even and at least 4");
      end
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
         $error("mp9_uart: DATA_W out of range 5..16");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("mp9_uart: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic            loop_on, tx_line, rxd_s, rx_in;
   logic            rx_done, rx_stop_ok;
   logic [DATA_W:0] rx_char, buf_w;

   assign loop_on = (cfg_loop_sel == LOOP_ON);

   mpu9_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(rxd), .d_out(rxd_s));

   mpu9_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(tx_wr),
      .data(tx_data), .bit9(tx_bit9), .stop2(cfg_stop2),
      .busy(tx_busy), .line(tx_line));

   assign rx_in = loop_on ? tx_line : rxd_s;

   mpu9_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx_in(rx_in),
      .done(rx_done), .char_o(rx_char), .stop_ok(rx_stop_ok));

   mpu9_rxctl #(.DATA_W(DATA_W), .ATTN_RST(ATTN_RST)) u_ctl (
      .clk(clk), .rst_n(rst_n), .done(rx_done), .char_in(rx_char),
      .stop_ok(rx_stop_ok), .rd(rx_read), .attn_set(attn_set),
      .irq_en(rx_irq_en), .buf_o(buf_w), .full(rx_full), .ferr(rx_ferr),
      .ovr(rx_ovr), .attn(attn_mode), .irq(rx_irq));

   assign rx_data = buf_w[DATA_W-1:0];
   assign rx_bit9 = buf_w[DATA_W];
   assign txd     = cfg_break ? 1'b0 : (loop_on ? 1'b1 : tx_line);
endmodule

// File: tb/sim_mp9_uart.sv
module sim_mp9_uart;
   logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
   logic       cfg_stop2 = 1'b0, cfg_break = 1'b0, tx_wr = 1'b0, tx_bit9 = 1'b0;
   logic [1:0] cfg_loop_sel = 2'b00;
   logic [7:0] tx_data = 8'h00, rx_data;
   logic       attn_set = 1'b0, rx_irq_en = 1'b1, rx_read = 1'b0, rxd = 1'b1;
   logic       tx_busy, attn_mode, rx_bit9, rx_full, rx_ferr, rx_ovr, rx_irq, txd;

   int tests = 0, fails = 0, tick_div = 4, tdiv = 0;
   bit cmp_en = 1'b0, started = 1'b0;
   // reference model state
   bit       m_full = 0, m_ferr = 0, m_ovr = 0, m_attn = 0;
   bit [8:0] m_data = '0;

   always #2 clk = ~clk;

   mp9_uart u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_stop2(cfg_stop2),
      .cfg_loop_sel(cfg_loop_sel), .cfg_break(cfg_break), .tx_wr(tx_wr),
      .tx_data(tx_data), .tx_bit9(tx_bit9), .tx_busy(tx_busy), .attn_set(attn_set),
      .attn_mode(attn_mode), .rx_irq_en(rx_irq_en), .rx_read(rx_read),
      .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full), .rx_ferr(rx_ferr),
      .rx_ovr(rx_ovr), .rx_irq(rx_irq), .rxd(rxd), .txd(txd));

   initial forever begin
      @(negedge clk);
      tdiv++;
      baud_tick = ((tdiv % tick_div) == 0);
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (started) begin
         if (cfg_break)                 chk(txd == 1'b0, "R13", "txd under break", txd, 0);
         else if (cfg_loop_sel == 2'b11) chk(txd == 1'b1, "R12", "txd in loopback", txd, 1);
         if (cmp_en) begin
            chk(rx_full == m_full, "R4", "rx_full", rx_full, m_full);
            chk(rx_irq == (m_full && rx_irq_en), "R4", "rx_irq", rx_irq, m_full);
            chk(attn_mode == m_attn, "R10", "attn_mode", attn_mode, m_attn);
            chk(rx_ovr == m_ovr, "R7", "rx_ovr", rx_ovr, m_ovr);
            chk(rx_ferr == m_ferr, "R6", "rx_ferr", rx_ferr, m_ferr);
         end
      end
   end

   task automatic wait_ticks(input int n);
      repeat (n) begin
         do @(posedge clk); while (!baud_tick);
      end
   endtask

   task automatic model_rx(input bit b9, input bit [7:0] d, input bit stop_ok);
      if (!m_attn || b9) begin
         if (m_full) m_ovr = 1;
         m_full = 1;
         m_data = {b9, d};
         if (!stop_ok) m_ferr = 1;
         m_attn = 0;
      end
   endtask

   task automatic check_rx(input string req);
      chk(rx_full == m_full, req, "rx_full", rx_full, m_full);
      if (m_full) chk({rx_bit9, rx_data} == m_data, req, "rx char", {rx_bit9, rx_data}, m_data);
      chk(attn_mode == m_attn, req, "attn_mode", attn_mode, m_attn);
      chk(rx_ovr == m_ovr, req, "rx_ovr", rx_ovr, m_ovr);
      chk(rx_ferr == m_ferr, req, "rx_ferr", rx_ferr, m_ferr);
   endtask

   task automatic send_rx(input bit b9, input bit [7:0] d, input bit stop_v, input string req);
      cmp_en = 0;
      @(negedge clk) rxd = 1'b0;
      wait_ticks(16);
      for (int k = 0; k < 9; k++) begin
         @(negedge clk) rxd = (k == 8) ? b9 : d[k];
         wait_ticks(16);
      end
      @(negedge clk) rxd = stop_v;
      wait_ticks(stop_v ? 16 : 12);
      @(negedge clk) rxd = 1'b1;
      wait_ticks(24);
      @(negedge clk);
      model_rx(b9, d, stop_v);
      check_rx(req);
      cmp_en = 1;
   endtask

   task automatic host_read();
      cmp_en = 0;
      @(negedge clk) rx_read = 1'b1;
      @(negedge clk) rx_read = 1'b0;
      m_full = 0; m_ferr = 0; m_ovr = 0;
      check_rx("R5");
      cmp_en = 1;
   endtask

   task automatic arm_attn();
      cmp_en = 0;
      @(negedge clk) attn_set = 1'b1;
      @(negedge clk) attn_set = 1'b0;
      m_attn = 1;
      chk(attn_mode == 1'b1, "R10", "attn after set", attn_mode, 1);
      cmp_en = 1;
   endtask

   // drives one write and samples the pin at the middle of every bit
   task automatic tx_check(input bit b9, input bit [7:0] d, input bit two, input string req);
      bit [11:0] fr;
      int nb;
      fr = {2'b11, b9, d, 1'b0};
      nb = two ? 12 : 11;
      @(negedge clk);
      cfg_stop2 = two; tx_data = d; tx_bit9 = b9; tx_wr = 1'b1;
      @(negedge clk) tx_wr = 1'b0;
      chk(tx_busy == 1'b1, "R2", "busy after write", tx_busy, 1);
      for (int k = 0; k < nb; k++) begin
         wait_ticks(k == 0 ? 8 : 16);
         @(negedge clk);
         chk(txd == fr[k], req, $sformatf("tx bit %0d", k), txd, fr[k]);
         if (k == 3) begin
            tx_data = ~d; tx_bit9 = ~b9; tx_wr = 1'b1;   // R2: must be ignored
            @(negedge clk) tx_wr = 1'b0;
         end
      end
      chk(tx_busy == 1'b1, "R2", "busy in last stop", tx_busy, 1);
      wait_ticks(8);
      @(negedge clk);
      chk(tx_busy == 1'b0, "R2", "busy after frame", tx_busy, 0);
      chk(txd == 1'b1, "R1", "idle line", txd, 1);
   endtask

   task automatic loop_tx(input bit b9, input bit [7:0] d, input string req);
      cmp_en = 0;
      @(negedge clk);
      cfg_stop2 = 1'b0; tx_data = d; tx_bit9 = b9; tx_wr = 1'b1;
      @(negedge clk) tx_wr = 1'b0;
      while (tx_busy) @(negedge clk);
      wait_ticks(8);
      @(negedge clk);
      model_rx(b9, d, 1'b1);
      check_rx(req);
      cmp_en = 1;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1 && tx_busy == 1'b0, "R2", "reset tx idle", {tx_busy, txd}, 1);
      chk(rx_full == 1'b0 && rx_irq == 1'b0, "R4", "reset rx empty", {rx_full, rx_irq}, 0);
      chk(attn_mode == 1'b0, "R10", "reset attn", attn_mode, 0);
      started = 1; cmp_en = 1;

      send_rx(1'b0, 8'hA5, 1'b1, "R4");
      host_read();
      send_rx(1'b1, 8'h3C, 1'b1, "R4");
      send_rx(1'b0, 8'h0F, 1'b1, "R7");
      host_read();
      send_rx(1'b0, 8'h55, 1'b0, "R6");
      host_read();

      // R3: short low pulse
      cmp_en = 0;
      @(negedge clk) rxd = 1'b0;
      wait_ticks(3);
      @(negedge clk) rxd = 1'b1;
      wait_ticks(40);
      @(negedge clk);
      check_rx("R3");
      cmp_en = 1;

      arm_attn();
      send_rx(1'b0, 8'h11, 1'b1, "R8");
      send_rx(1'b1, 8'h22, 1'b1, "R9");
      host_read();
      send_rx(1'b0, 8'h33, 1'b1, "R9");
      host_read();
      arm_attn();
      send_rx(1'b0, 8'h44, 1'b1, "R8");

      tx_check(1'b1, 8'hC3, 1'b0, "R11");
      cfg_loop_sel = 2'b01;
      tx_check(1'b0, 8'h5A, 1'b1, "R12");
      cfg_loop_sel = 2'b00;

      cfg_break = 1'b1;
      @(negedge clk) tx_data = 8'hFF; tx_bit9 = 1'b1; tx_wr = 1'b1;
      @(negedge clk) tx_wr = 1'b0;
      while (tx_busy) @(negedge clk);
      chk(txd == 1'b0, "R13", "break idle", txd, 0);
      cfg_break = 1'b0;
      @(negedge clk);
      chk(txd == 1'b1, "R13", "break released", txd, 1);

      // loopback, attention still armed; rxd held low must be ignored
      cfg_loop_sel = 2'b11;
      rxd = 1'b0;
      loop_tx(1'b0, 8'h77, "R12");
      loop_tx(1'b1, 8'h81, "R12");

      // R14: completion and read on the same edge
      tick_div = 1;
      repeat (4) @(negedge clk);
      cmp_en = 0;
      cfg_stop2 = 1'b0; tx_data = 8'h96; tx_bit9 = 1'b0; tx_wr = 1'b1;
      @(negedge clk) tx_wr = 1'b0;
      repeat (167) @(negedge clk);
      rx_read = 1'b1;
      repeat (2) @(negedge clk);
      rx_read = 1'b0;
      chk(rx_full == 1'b1, "R14", "full after collide", rx_full, 1);
      chk(rx_ovr == 1'b0, "R14", "no overrun", rx_ovr, 0);
      chk({rx_bit9, rx_data} == 9'h096, "R14", "new char kept", {rx_bit9, rx_data}, 9'h096);
      m_full = 1; m_data = 9'h096; m_ovr = 0; m_ferr = 0;
      while (tx_busy) @(negedge clk);
      repeat (40) @(negedge clk);
      cmp_en = 1;
      tick_div = 4;
      host_read();
      @(negedge clk) rxd = 1'b1;
      cfg_loop_sel = 2'b00;
      repeat (20) @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule